// File: doc/BRIEF.md
# Load-Adaptive Operating Point Selector

This block picks one of four operating points for a data-driven transform engine, one block at a time. While a block of coefficients streams in, it counts the strobes that mark non-zero coefficients. At the next block-start strobe it turns that count into a supply-level code and a matching clock-period code. It then holds both codes for the whole processing period of that block. The external regulator and the clock generator follow these two codes.

The block also drives a registered enable for the processing clock. The enable turns on at a block boundary when the new block has work in it. It turns off as soon as the engine raises its done flag. This way the clock is off for the slack left in each block period. If a new block arrives while the engine is still busy, the block raises a one-cycle overrun pulse. It then runs the next block at the fastest operating point, whatever that block's count is.

Top module: `load_opsel`

## Requirements
- R1: While reset is held low at a clock edge, after that edge `lvl_code` is 0, `per_sel` is 3, and `clk_en` and `overrun` are both 0.
- R2: The count for a block is the number of cycles with `nz_vld` high, from the cycle that carries `blk_start` up to the cycle before the next `blk_start`. The count stops growing at 64 and does not wrap.
- R3: At a block start the level code comes from the finished count: 0 to 2 gives level 0, 3 to 4 gives level 1, 5 to 8 gives level 2, and 9 or more gives level 3.
- R4: `per_sel` is always 3 minus `lvl_code`. Code 0 is the shortest clock period and goes with level 3, the highest supply.
- R5: `lvl_code` and `per_sel` change only in the cycle that follows a `blk_start` cycle.
- R6: After a block start, `clk_en` is 1 if the finished count is non-zero and 0 if it is zero. In a cycle without `blk_start`, `comp_done` high clears `clk_en` from the next cycle on.
- R7: If `blk_start` arrives while `clk_en` is 1 and `comp_done` is low, `overrun` is high for exactly the next cycle. The level for that block is then forced to 3.
- R8: If `comp_done` is high in the same cycle as `blk_start`, the old block counts as finished and no overrun is raised.
- R9: `clk_en` changes only in the cycle after a `blk_start` or after a `comp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_start | input | 1 | One-cycle strobe that opens a new block period |
| nz_vld | input | 1 | High in a cycle that delivers a non-zero coefficient |
| comp_done | input | 1 | Engine has finished the block now being processed |
| lvl_code | output | 2 | Supply level code, 0 lowest to 3 highest |
| per_sel | output | 2 | Clock period code, 0 shortest |
| clk_en | output | 1 | Registered enable for the processing clock |
| overrun | output | 1 | One-cycle pulse: block start arrived before done |

## Verification
The assertions assume that `blk_start` is never high in two back-to-back cycles, and that `nz_vld` is high at most once per cycle. They also assume that `comp_done` is only meaningful while the engine is busy. The stimulus keeps to these rules. It places block starts exactly 64 cycles apart, except in one long window. In that window the starts are held off for well over 64 valid strobes so that the counter reaches its ceiling. It drives `comp_done` at set offsets inside the period, or in the same cycle as the next start, or not at all.

// File: rtl/load_opsel_pkg.sv
// Shared types and encodings for the load-adaptive operating point selector.
// Assumes four operating points, so the level and period codes are 2 bits wide.
package load_opsel_pkg;
    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_MIN = 2'd0;
    localparam lvl_t LVL_MAX = 2'd3;
endpackage

// File: rtl/nz_counter.sv
// Counts the non-zero coefficient strobes in one block window.
// Assumes at most one strobe per cycle. A strobe in the block-start cycle
// opens the new window. The count sticks at BLOCK_LEN.
module nz_counter #(
    parameter int BLOCK_LEN = 64,
    localparam int CNT_W = $clog2(BLOCK_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_start,
    input  logic             nz_vld,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLOCK_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             chk_ok;

    // Restart at each block boundary, otherwise step with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (blk_start) begin
            cnt_q <= nz_vld ? CNT_W'(1) : '0;
        end else if (nz_vld && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Marks cycles whose history lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_ok <= 1'b0;
        else        chk_ok <= 1'b1;
    end

    assign cnt = cnt_q;

    // R2: the count never goes past the block length.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R2: the count cannot move while no strobe and no start arrive.
    a_r2_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        (!$past(blk_start) && !$past(nz_vld)) |-> $stable(cnt_q));
endmodule

// File: rtl/level_map.sv
// Turns a finished non-zero count into a level code with three upper-bound
// thresholds. The thresholds are assumed to be strictly increasing.
module level_map
    import load_opsel_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int TH_L0 = 2,
    parameter int TH_L1 = 4,
    parameter int TH_L2 = 8
) (
    input  logic [CNT_W-1:0] cnt,
    output lvl_t             lvl
);
    // Compare against each bound and pick the lowest level that fits.
    always_comb begin
        if (cnt <= CNT_W'(TH_L0))      lvl = LVL_MIN;
        else if (cnt <= CNT_W'(TH_L1)) lvl = 2'd1;
        else if (cnt <= CNT_W'(TH_L2)) lvl = 2'd2;
        else                           lvl = LVL_MAX;
    end
endmodule

// File: rtl/gate_ctrl.sv
// Block-boundary control. It latches the level, sets and clears the
// processing clock enable, and flags an overrun. It assumes blk_start is a
// one-cycle strobe that never comes in two back-to-back cycles.
module gate_ctrl
    import load_opsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_start,
    input  logic comp_done,
    input  logic cnt_nz,
    input  lvl_t lvl_next,
    output lvl_t lvl,
    output logic clk_en,
    output logic overrun
);
    lvl_t lvl_q;
    logic en_q;
    logic ovr_q;
    logic chk_ok;
    logic late;

    assign late = en_q && !comp_done;

    // Boundary latch, done-driven gating and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_MIN;
            en_q  <= 1'b0;
            ovr_q <= 1'b0;
        end else if (blk_start) begin
            ovr_q <= late;
            lvl_q <= late ? LVL_MAX : lvl_next;
            en_q  <= cnt_nz;
        end else begin
            ovr_q <= 1'b0;
            if (comp_done) en_q <= 1'b0;
        end
    end

    // Marks cycles whose history lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_ok <= 1'b0;
        else        chk_ok <= 1'b1;
    end

    assign lvl     = lvl_q;
    assign clk_en  = en_q;
    assign overrun = ovr_q;

    // R5: the level holds except right after a block start.
    a_r5_lvl_hold: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        !$past(blk_start) |-> $stable(lvl_q));

    // R7: an overrun always runs at the top operating point.
    a_r7_ovr_top: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> (lvl_q == LVL_MAX));

    // R7: an overrun pulse only follows a block start.
    a_r7_ovr_after_start: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        ovr_q |-> $past(blk_start));

    // R9: the enable rises only after a block start.
    a_r9_en_rise: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        $rose(en_q) |-> $past(blk_start));

    // R9: the enable falls only after a block start or a done.
    a_r9_en_fall: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        $fell(en_q) |-> ($past(blk_start) || $past(comp_done)));
endmodule

// File: rtl/load_opsel.sv
// Top of the load-adaptive operating point selector. It ties the per-block
// non-zero counter, the threshold map and the boundary control together, and
// derives the clock period code that pairs with the level.
// Assumes blk_start strobes are at least two cycles apart.
module load_opsel
    import load_opsel_pkg::*;
#(
    parameter int BLOCK_LEN = 64,
    parameter int TH_L0 = 2,
    parameter int TH_L1 = 4,
    parameter int TH_L2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_start,
    input  logic       nz_vld,
    input  logic       comp_done,
    output logic [1:0] lvl_code,
    output logic [1:0] per_sel,
    output logic       clk_en,
    output logic       overrun
);
    localparam int CNT_W = $clog2(BLOCK_LEN + 1);

    logic [CNT_W-1:0] nz_cnt;
    lvl_t             lvl_next;
    lvl_t             lvl_cur;
    logic             chk_ok;

    nz_counter #(.BLOCK_LEN(BLOCK_LEN)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .nz_vld    (nz_vld),
        .cnt       (nz_cnt)
    );

    level_map #(.CNT_W(CNT_W), .TH_L0(TH_L0), .TH_L1(TH_L1), .TH_L2(TH_L2)) u_map (
        .cnt (nz_cnt),
        .lvl (lvl_next)
    );

    gate_ctrl u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .comp_done (comp_done),
        .cnt_nz    (nz_cnt != '0),
        .lvl_next  (lvl_next),
        .lvl       (lvl_cur),
        .clk_en    (clk_en),
        .overrun   (overrun)
    );

    // Higher supply pairs with a shorter clock period.
    assign lvl_code = lvl_cur;
    assign per_sel  = LVL_MAX - lvl_cur;

    // Marks cycles whose history lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_ok <= 1'b0;
        else        chk_ok <= 1'b1;
    end

    // R6: a block with no non-zero coefficients leaves the clock gated.
    a_r6_zero_gated: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
        ($past(blk_start) && ($past(nz_cnt) == '0)) |-> !clk_en);
endmodule

// File: tb/load_opsel_tb.sv
module load_opsel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_start = 1'b0;
    logic       nz_vld = 1'b0;
    logic       comp_done = 1'b0;
    logic [1:0] lvl_code;
    logic [1:0] per_sel;
    logic       clk_en;
    logic       overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit pend_done = 1'b0;

    always #5 clk = ~clk;

    load_opsel u_dut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .nz_vld(nz_vld),
        .comp_done(comp_done), .lvl_code(lvl_code), .per_sel(per_sel),
        .clk_en(clk_en), .overrun(overrun)
    );

    // Per-period stimulus: strobe count, done offset (-1 none, 64 with next
    // start) and the outputs expected right after the next block start.
    localparam int NV = 16;
    localparam int V_N  [NV] = '{0, 2, 3, 4, 5, 8, 9, 64, 1, 1, 16, 0, 0, 6, 3, 2};
    localparam int V_DN [NV] = '{-1, -1, 10, 20, 30, 40, 50, 63, -1, 5, 5, -1, -1, -1, 64, -1};
    localparam int V_LVL[NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 3, 0, 3, 3, 0, 2, 1, 3};
    localparam int V_OVR[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 1};
    localparam int V_EN [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One 64-cycle block period; checks the previous row after its boundary.
    task automatic run_period(input int n, input int dn, input int idx);
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (c == 1 && idx >= 0) begin
                chk($sformatf("R3 R7 R8 level row %0d", idx), lvl_code, V_LVL[idx]);
                chk($sformatf("R4 period row %0d", idx), per_sel, 3 - V_LVL[idx]);
                chk($sformatf("R7 R8 overrun row %0d", idx), overrun, V_OVR[idx]);
                chk($sformatf("R6 enable row %0d", idx), clk_en, V_EN[idx]);
            end
            if (c == 2) chk("R7 overrun single cycle", overrun, 0);
            if (c == 40 && idx >= 0)
                chk("R5 level held in period", lvl_code, V_LVL[idx]);
            if (dn >= 0 && dn < 63 && c == dn + 1)
                chk("R6 done gates clock", clk_en, 0);
            blk_start = (c == 0);
            nz_vld    = (c < n);
            comp_done = (c == dn) || (c == 0 && pend_done);
        end
        pend_done = (dn == 64);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset level", lvl_code, 0);
        chk("R1 reset period", per_sel, 3);
        chk("R1 reset enable", clk_en, 0);
        chk("R1 reset overrun", overrun, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_period(V_N[i], V_DN[i], i - 1);
        run_period(0, -1, NV - 1);

        // R2: hold off the start past 128 strobes; the count must stick at 64.
        @(negedge clk);
        blk_start = 1'b1; nz_vld = 1'b1; comp_done = 1'b0;
        for (int k = 0; k < 129; k++) begin
            @(negedge clk);
            blk_start = 1'b0; nz_vld = 1'b1;
        end
        @(negedge clk);
        blk_start = 1'b1; nz_vld = 1'b0;
        @(negedge clk);
        blk_start = 1'b0;
        chk("R2 saturated count level", lvl_code, 3);
        chk("R2 saturated count overrun", overrun, 0);
        chk("R6 saturated count enable", clk_en, 1);

        // R9: a stray done-free gap leaves the enable alone.
        repeat (5) @(negedge clk);
        chk("R9 enable steady without done", clk_en, 1);

        // R1: reset in the middle of a busy block.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run reset level", lvl_code, 0);
        chk("R1 mid-run reset period", per_sel, 3);
        chk("R1 mid-run reset enable", clk_en, 0);
        chk("R1 mid-run reset overrun", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule